// File: doc/BRIEF.md
# Filtered Segment Bus Controller

This controller sits where one local bus segment of a snooping multicore interconnect meets the shared central bus. Each cycle it picks at most one local requester and broadcasts that request on the segment's local bus. It then uses two counting Bloom filters to decide whether the transaction can stay inside the segment. The home filter is a superset of this segment's own lines that have ever been requested from another segment. The presence filter is a superset of the lines cached inside the segment.

A request for a home line that misses the home filter finishes locally, and the controller raises a validate pulse for it. Any other request is copied into a single held entry and offered to the central bus until the central bus grants it. While that entry is occupied, requesters whose transaction would need the central bus are held back. Requests that can finish locally are still served. Transactions seen on the central bus are rebroadcast into the segment only when the presence filter reports a possible hit, and they take the local bus ahead of local requesters. Central-bus traffic for a home line is recorded in the home filter. Line fills and evictions maintain the presence filter.

Top module: `seg_bus_ctrl`

## Requirements
- R1: During and directly after synchronous active-low reset, gnt, stall, lbus_valid, lbus_from_central, validate and cbus_req are all 0, and both filters are empty.
- R2: gnt is combinational in the cycle of the request. At most one bit is set, and only for an eligible requester. Grants rotate round-robin after the last granted index, and index 0 has first priority after reset.
- R3: A grant in cycle t gives lbus_valid=1, lbus_from_central=0 and lbus_addr equal to the granted address in cycle t+1.
- R4: A line is home when its top SEG_W address bits equal SEG_ID. A granted request for a home line that misses the home filter raises validate in cycle t+1 and does not load the held entry.
- R5: A granted request for a non-home line, or for a line that hits the home filter, loads the held entry. cbus_req is then 1 from t+1 with cbus_addr held. It stays there up to and including the cycle in which cbus_gnt is sampled high, and it is 0 in the cycle after.
- R6: stall equals the occupancy of the held entry. While it is occupied, a requester whose request needs the central bus is not granted, and requests that can finish locally are still granted.
- R7: When cin_valid is high and cin_addr possibly hits the presence filter, no local grant is given in that cycle. In the next cycle lbus_valid=1, lbus_from_central=1 and lbus_addr=cin_addr.
- R8: A central-bus transaction that misses the presence filter is not rebroadcast, and local arbitration proceeds in that cycle.
- R9: cin_valid for a home line inserts the line into the home filter. From the next cycle, local requests for that line go to the central bus.
- R10: A line is present when its counters are nonzero in both arrays. Array 0 is indexed by addr[IDX_W-1:0]. Array 1 is indexed by addr[2*IDX_W-1:IDX_W] XOR the remaining upper address bits. fill_valid inserts into the presence filter and evict_valid removes from it, with the effect visible the next cycle.
- R11: A counter saturates at its maximum and then never decrements. An insert and a removal hitting the same counter in one cycle leave it unchanged.
- R12: validate is never high in the cycle in which cbus_req rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_REQ | Local requester request lines |
| req_addr | input | N_REQ x ADDR_W | Line address per requester |
| gnt | output | N_REQ | One-hot local grant, same cycle |
| stall | output | 1 | Back-pressure: held entry occupied |
| lbus_valid | output | 1 | Local bus broadcast valid |
| lbus_addr | output | ADDR_W | Local bus broadcast address |
| lbus_from_central | output | 1 | Broadcast originates from the central bus |
| validate | output | 1 | Transaction completed locally |
| cbus_req | output | 1 | Central bus request |
| cbus_addr | output | ADDR_W | Address of the held entry |
| cbus_gnt | input | 1 | Central bus grant |
| cin_valid | input | 1 | Central bus transaction observed |
| cin_addr | input | ADDR_W | Address of observed central transaction |
| fill_valid | input | 1 | Line filled into the segment |
| fill_addr | input | ADDR_W | Filled line address |
| evict_valid | input | 1 | Line evicted from the segment |
| evict_addr | input | ADDR_W | Evicted line address |

## Verification
The grant is due in the same cycle as its request, so the bench compares gnt one nanosecond after it drives the inputs. The local broadcast, the validate pulse, the rise of cbus_req and the stall flag are due one clock edge after the grant. The release of the held entry is due one edge after cbus_gnt is sampled, and filter updates affect decisions from the cycle after the insert or removal. The bench drives inputs at the falling edge and checks gnt after the settle delay. It advances its behavioural model at the rising edge and compares every registered output at the next falling edge, so each result is sampled in exactly the cycle it is due.

// File: rtl/seg_bus_pkg.sv
// Shared types for the filtered segment bus controller.
// Assumes: nothing beyond IEEE 1800-2017.
package seg_bus_pkg;

    // Kind of beat placed on the local bus in the following cycle.
    typedef enum logic [1:0] {
        BEAT_IDLE       = 2'd0,
        BEAT_LOCAL_DONE = 2'd1,
        BEAT_LOCAL_ESC  = 2'd2,
        BEAT_CENTRAL    = 2'd3
    } beat_kind_e;

endpackage

// File: rtl/cbf_filter.sv
// Counting Bloom filter with two hashed counter arrays.
// Insert increments and remove decrements one counter per array. Counters
// saturate and stick at their maximum. Membership means both counters are
// nonzero, which allows false positives and never false negatives.
// Assumes: ADDR_W > 2*IDX_W and ADDR_W - 2*IDX_W <= IDX_W.
module cbf_filter #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 4,
    parameter int N_QRY  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins_en,
    input  logic [ADDR_W-1:0]            ins_addr,
    input  logic                         del_en,
    input  logic [ADDR_W-1:0]            del_addr,
    input  logic [N_QRY-1:0][ADDR_W-1:0] qry_addr,
    output logic [N_QRY-1:0]             qry_hit
);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int N_HASH = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Index of address a into hash array k.
    function automatic logic [IDX_W-1:0] hidx(input int unsigned k,
                                              input logic [ADDR_W-1:0] a);
        if (k == 0) return a[IDX_W-1:0];
        return a[2*IDX_W-1:IDX_W] ^ IDX_W'(a[ADDR_W-1:2*IDX_W]);
    endfunction

    logic [N_HASH-1:0][N_QRY-1:0] arr_hit;

    for (genvar h = 0; h < N_HASH; h++) begin : g_hash
        logic [CNT_W-1:0] cnt [DEPTH];
        logic [IDX_W-1:0] ins_i, del_i;
        logic [DEPTH-1:0] inc_v, dec_v;

        assign ins_i = hidx(h, ins_addr);
        assign del_i = hidx(h, del_addr);

        // Decode the insert and remove strobes onto one bit per counter.
        always_comb begin
            for (int j = 0; j < DEPTH; j++) begin
                inc_v[j] = ins_en && (ins_i == IDX_W'(j));
                dec_v[j] = del_en && (del_i == IDX_W'(j));
            end
        end

        // Update counters: saturating up, sticky at max, floor at zero.
        always_ff @(posedge clk) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (!rst_n) begin
                    cnt[j] <= '0;
                end else if (inc_v[j] && !dec_v[j] && cnt[j] != CNT_MAX) begin
                    cnt[j] <= cnt[j] + 1'b1;
                end else if (dec_v[j] && !inc_v[j] && cnt[j] != '0 && cnt[j] != CNT_MAX) begin
                    cnt[j] <= cnt[j] - 1'b1;
                end
            end
        end

        for (genvar q = 0; q < N_QRY; q++) begin : g_qry
            assign arr_hit[h][q] = (cnt[hidx(h, qry_addr[q])] != '0);
        end
    end

    // A query hits only when every array reports a nonzero counter.
    always_comb begin
        for (int q = 0; q < N_QRY; q++) begin
            qry_hit[q] = 1'b1;
            for (int h = 0; h < N_HASH; h++) qry_hit[q] = qry_hit[q] & arr_hit[h][q];
        end
    end

endmodule

// File: rtl/rr_pick.sv
// Round-robin picker. The grant is combinational from req. Priority starts
// just after the last granted index, and index 0 comes first after reset.
// Assumes: N >= 2.
module rr_pick #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gidx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] last_q;
    logic [N-1:0]  hi_req;

    // Pick the lowest request above last_q, else the lowest overall.
    always_comb begin
        gnt  = '0;
        gidx = '0;
        for (int i = 0; i < N; i++) hi_req[i] = req[i] && (i > int'(last_q));
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt  = '0;
                gnt[i] = 1'b1;
                gidx = IW'(i);
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (hi_req[i] && |hi_req) begin
                gnt  = '0;
                gnt[i] = 1'b1;
                gidx = IW'(i);
            end
        end
    end

    // Remember the last granted index.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= IW'(N - 1);
        else if (|gnt) last_q <= gidx;
    end

endmodule

// File: rtl/hold_entry.sv
// Single held entry for a transaction waiting for the central bus.
// Assumes: load is only asserted while the entry is empty.
module hold_entry #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] din,
    input  logic              taken,
    output logic              full,
    output logic [ADDR_W-1:0] dout
);
    // Fill on load and empty once the central bus grant is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (full && taken) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/seg_bus_ctrl.sv
// Filtered segment bus controller: arbitrates local requesters and
// broadcasts on the local bus. It decides via the home filter whether a
// request finishes locally or must be escalated through a single held
// entry, and it forwards central-bus traffic that hits the presence filter.
// Assumes: ADDR_W > SEG_W, home lines carry SEG_ID in their top SEG_W bits.
module seg_bus_ctrl
    import seg_bus_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 2,
    parameter int SEG_ID = 1,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_REQ-1:0]             req,
    input  logic [N_REQ-1:0][ADDR_W-1:0] req_addr,
    output logic [N_REQ-1:0]             gnt,
    output logic                         stall,
    output logic                         lbus_valid,
    output logic [ADDR_W-1:0]            lbus_addr,
    output logic                         lbus_from_central,
    output logic                         validate,
    output logic                         cbus_req,
    output logic [ADDR_W-1:0]            cbus_addr,
    input  logic                         cbus_gnt,
    input  logic                         cin_valid,
    input  logic [ADDR_W-1:0]            cin_addr,
    input  logic                         fill_valid,
    input  logic [ADDR_W-1:0]            fill_addr,
    input  logic                         evict_valid,
    input  logic [ADDR_W-1:0]            evict_addr
);
    localparam int IW = $clog2(N_REQ);

    // True when address a belongs to this segment.
    function automatic logic is_home(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SEG_W] == SEG_W'(SEG_ID);
    endfunction

    logic [N_REQ-1:0] out_hit, needs_cb, eligible, arb_req;
    logic             in_hit, cin_hit, g_any, g_needs, buf_full;
    logic [IW-1:0]    gidx;
    logic [ADDR_W-1:0] buf_addr;
    beat_kind_e        beat_q;
    logic [ADDR_W-1:0] beat_addr_q;

    cbf_filter #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .N_QRY(N_REQ)) u_home_filt (
        .clk(clk), .rst_n(rst_n),
        .ins_en(cin_valid && is_home(cin_addr)), .ins_addr(cin_addr),
        .del_en(1'b0), .del_addr('0),
        .qry_addr(req_addr), .qry_hit(out_hit)
    );

    cbf_filter #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .N_QRY(1)) u_pres_filt (
        .clk(clk), .rst_n(rst_n),
        .ins_en(fill_valid), .ins_addr(fill_addr),
        .del_en(evict_valid), .del_addr(evict_addr),
        .qry_addr(cin_addr), .qry_hit(in_hit)
    );

    // Classify each requester and mask escalations while the entry is busy.
    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            needs_cb[i] = !is_home(req_addr[i]) || out_hit[i];
            eligible[i] = req[i] && !(buf_full && needs_cb[i]);
        end
    end

    assign cin_hit = cin_valid && in_hit;
    assign arb_req = cin_hit ? '0 : eligible;

    rr_pick #(.N(N_REQ)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(arb_req), .gnt(gnt), .gidx(gidx)
    );

    assign g_any   = |gnt;
    assign g_needs = needs_cb[gidx];

    hold_entry #(.ADDR_W(ADDR_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .load(g_any && g_needs), .din(req_addr[gidx]),
        .taken(cbus_gnt), .full(buf_full), .dout(buf_addr)
    );

    // Register the local-bus beat: central traffic first, then the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q      <= BEAT_IDLE;
            beat_addr_q <= '0;
        end else if (cin_hit) begin
            beat_q      <= BEAT_CENTRAL;
            beat_addr_q <= cin_addr;
        end else if (g_any) begin
            beat_q      <= g_needs ? BEAT_LOCAL_ESC : BEAT_LOCAL_DONE;
            beat_addr_q <= req_addr[gidx];
        end else begin
            beat_q      <= BEAT_IDLE;
        end
    end

    assign lbus_valid        = (beat_q != BEAT_IDLE);
    assign lbus_addr         = beat_addr_q;
    assign lbus_from_central = (beat_q == BEAT_CENTRAL);
    assign validate          = (beat_q == BEAT_LOCAL_DONE);
    assign cbus_req          = buf_full;
    assign cbus_addr         = buf_addr;
    assign stall             = buf_full;

endmodule

// File: rtl/seg_bus_ctrl_chk.sv
// Temporal checks on the controller's ports, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module seg_bus_ctrl_chk #(
    parameter int N_REQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req,
    input logic [N_REQ-1:0] gnt,
    input logic             stall,
    input logic             lbus_valid,
    input logic             lbus_from_central,
    input logic             validate,
    input logic             cbus_req,
    input logic             cbus_gnt
);
    a_r2_onehot_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r2_gnt_only_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    a_r3_grant_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (lbus_valid && !lbus_from_central));
    a_r4_validate_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        validate |-> (lbus_valid && !lbus_from_central));
    a_r5_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (cbus_req && !cbus_gnt) |=> cbus_req);
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cbus_req && cbus_gnt) |=> !cbus_req);
    a_r6_stall_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> cbus_req);
    a_r7_central_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lbus_from_central |-> ($past(gnt) == '0));
    a_r12_no_dual: assert property (@(posedge clk) disable iff (!rst_n)
        validate |-> !$rose(cbus_req));
endmodule

bind seg_bus_ctrl seg_bus_ctrl_chk #(.N_REQ(N_REQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .stall(stall),
    .lbus_valid(lbus_valid), .lbus_from_central(lbus_from_central),
    .validate(validate), .cbus_req(cbus_req), .cbus_gnt(cbus_gnt)
);

// File: tb/sim_seg_bus_ctrl.sv
// Bench for seg_bus_ctrl: behavioural reference model compared every cycle,
// plus directed sequences for filter and arbitration corner cases.
module sim_seg_bus_ctrl;
    localparam int N = 4;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0][W-1:0] req_addr = '0;
    logic [N-1:0] gnt;
    logic stall, lbus_valid, lbus_from_central, validate, cbus_req;
    logic [W-1:0] lbus_addr, cbus_addr;
    logic cbus_gnt = 1'b0, cin_valid = 1'b0, fill_valid = 1'b0, evict_valid = 1'b0;
    logic [W-1:0] cin_addr = '0, fill_addr = '0, evict_addr = '0;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int inf [2][64];
    int outf [2][64];
    int m_last = N - 1;
    bit m_full = 0;
    int m_baddr = 0;
    bit m_lv = 0, m_lfc = 0, m_val = 0;
    int m_laddr = 0;

    always #5 clk = ~clk;

    seg_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .gnt(gnt),
        .stall(stall), .lbus_valid(lbus_valid), .lbus_addr(lbus_addr),
        .lbus_from_central(lbus_from_central), .validate(validate),
        .cbus_req(cbus_req), .cbus_addr(cbus_addr), .cbus_gnt(cbus_gnt),
        .cin_valid(cin_valid), .cin_addr(cin_addr), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .evict_valid(evict_valid), .evict_addr(evict_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int hx(input int k, input int a);
        if (k == 0) return a & 63;
        return ((a >> 6) & 63) ^ ((a >> 12) & 15);
    endfunction

    function automatic bit home(input int a);
        return ((a >> 14) & 3) == 1;
    endfunction

    function automatic bit in_hit(input int a);
        return inf[0][hx(0, a)] != 0 && inf[1][hx(1, a)] != 0;
    endfunction

    function automatic bit out_hit(input int a);
        return outf[0][hx(0, a)] != 0 && outf[1][hx(1, a)] != 0;
    endfunction

    // One clock: check the grant, advance the model, check registered outputs.
    task automatic step();
        int g;
        int exp_g;
        bit chit, nd, prev_cb;
        #1;
        chit = cin_valid && in_hit(int'(cin_addr));
        g = -1;
        if (!chit) begin
            for (int k = 1; k <= N; k++) begin
                int i;
                i = (m_last + k) % N;
                nd = !home(int'(req_addr[i])) || out_hit(int'(req_addr[i]));
                if (g < 0 && req[i] && !(m_full && nd)) g = i;
            end
        end
        exp_g = (g < 0) ? 0 : (1 << g);
        chk(gnt == N'(exp_g), "R2 grant", int'(gnt), exp_g);
        nd = (g >= 0) && (!home(int'(req_addr[g])) || out_hit(int'(req_addr[g])));
        m_lv = chit || (g >= 0);
        m_lfc = chit;
        if (chit) m_laddr = int'(cin_addr);
        else if (g >= 0) m_laddr = int'(req_addr[g]);
        m_val = (g >= 0) && !nd;
        prev_cb = m_full;
        if (g >= 0 && nd) begin m_full = 1; m_baddr = int'(req_addr[g]); end
        else if (m_full && cbus_gnt) m_full = 0;
        if (g >= 0) m_last = g;
        for (int k = 0; k < 2; k++) begin
            int ii, di;
            if (cin_valid && home(int'(cin_addr)) && outf[k][hx(k, int'(cin_addr))] != 15)
                outf[k][hx(k, int'(cin_addr))]++;
            ii = hx(k, int'(fill_addr));
            di = hx(k, int'(evict_addr));
            if (!(fill_valid && evict_valid && ii == di)) begin
                if (fill_valid && inf[k][ii] != 15) inf[k][ii]++;
                if (evict_valid && inf[k][di] != 0 && inf[k][di] != 15) inf[k][di]--;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(lbus_valid == m_lv, "R3 lbus_valid", int'(lbus_valid), int'(m_lv));
        if (m_lv) chk(int'(lbus_addr) == m_laddr, "R3 lbus_addr", int'(lbus_addr), m_laddr);
        chk(lbus_from_central == m_lfc, "R7 from_central", int'(lbus_from_central), int'(m_lfc));
        chk(validate == m_val, "R4 validate", int'(validate), int'(m_val));
        chk(cbus_req == m_full, "R5 cbus_req", int'(cbus_req), int'(m_full));
        if (m_full) chk(int'(cbus_addr) == m_baddr, "R5 cbus_addr", int'(cbus_addr), m_baddr);
        chk(stall == m_full, "R6 stall", int'(stall), int'(m_full));
        chk(!(validate && cbus_req && !prev_cb), "R12 validate with new cbus_req",
            int'(validate && cbus_req), 0);
    endtask

    task automatic quiet();
        req = '0; cin_valid = 0; fill_valid = 0; evict_valid = 0; cbus_gnt = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++)
            for (int j = 0; j < 64; j++) begin inf[k][j] = 0; outf[k][j] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({gnt, stall, lbus_valid, lbus_from_central, validate, cbus_req} == '0,
            "R1 reset outputs", int'({gnt, stall, lbus_valid, validate, cbus_req}), 0);
        rst_n = 1;

        // R4: home line never exported finishes locally.
        req[0] = 1; req_addr[0] = 16'h4005;
        step();
        chk(validate && !cbus_req, "R4 local completion", int'({validate, cbus_req}), 2);
        // R8: central traffic missing the presence filter is not forwarded.
        quiet(); cin_valid = 1; cin_addr = 16'h4005;
        step();
        chk(!lbus_valid, "R8 no rebroadcast", int'(lbus_valid), 0);
        // R9: the same line now leaves the segment.
        quiet(); req[1] = 1; req_addr[1] = 16'h4005;
        step();
        chk(cbus_req && cbus_addr == 16'h4005, "R9 escalated", int'(cbus_addr), 16'h4005);
        quiet(); cbus_gnt = 1;
        step();
        chk(!cbus_req, "R5 release", int'(cbus_req), 0);

        // R6: entry busy blocks escalations but not local completions.
        quiet(); req[2] = 1; req_addr[2] = 16'h8010;
        step();
        quiet(); req[0] = 1; req_addr[0] = 16'h8020; req[1] = 1; req_addr[1] = 16'h4033;
        step();
        chk(validate && stall, "R6 local served while stalled", int'({validate, stall}), 3);
        quiet(); cbus_gnt = 1;
        step();

        // R10 and R7: fill, forward with priority, then evict.
        quiet(); fill_valid = 1; fill_addr = 16'h0123;
        step();
        quiet(); cin_valid = 1; cin_addr = 16'h0123; req[0] = 1; req_addr[0] = 16'h4033;
        step();
        chk(lbus_from_central && lbus_addr == 16'h0123, "R7 forwarded first",
            int'(lbus_addr), 16'h0123);
        quiet(); evict_valid = 1; evict_addr = 16'h0123;
        step();
        quiet(); cin_valid = 1; cin_addr = 16'h0123;
        step();
        chk(!lbus_valid, "R10 evicted line not forwarded", int'(lbus_valid), 0);

        // R11: saturation sticks; simultaneous insert and remove cancel.
        quiet();
        for (int n = 0; n < 20; n++) begin fill_valid = 1; fill_addr = 16'h0A41; step(); end
        quiet();
        for (int n = 0; n < 20; n++) begin evict_valid = 1; evict_addr = 16'h0A41; step(); end
        quiet(); cin_valid = 1; cin_addr = 16'h0A41;
        step();
        chk(lbus_from_central, "R11 saturated counter kept", int'(lbus_from_central), 1);
        quiet(); fill_valid = 1; fill_addr = 16'h0C82; evict_valid = 1; evict_addr = 16'h0C82;
        step();
        quiet(); cin_valid = 1; cin_addr = 16'h0C82;
        step();
        chk(!lbus_valid, "R11 insert and remove cancel", int'(lbus_valid), 0);

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < N; i++) begin
                req[i] = ($urandom % 3) == 0;
                req_addr[i] = W'((($urandom % 4) << 14) | (($urandom % 8) * 16'h0041));
            end
            cin_valid = ($urandom % 4) == 0;
            cin_addr = W'((($urandom % 4) << 14) | (($urandom % 8) * 16'h0041));
            fill_valid = ($urandom % 5) == 0;
            fill_addr = W'((($urandom % 4) << 14) | (($urandom % 8) * 16'h0041));
            evict_valid = ($urandom % 7) == 0;
            evict_addr = W'((($urandom % 4) << 14) | (($urandom % 8) * 16'h0041));
            cbus_gnt = ($urandom % 3) == 0;
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule